// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block brings an SDR SDRAM device out of power-up. Software writes a 16-bit control word. Bit 15 of that word is the enable bit, and one further bit asks for a single command. The sequencer turns each accepted request into exactly one command cycle on the memory pins: chip select, row strobe, column strobe, write enable, address and bank. After each command it drives NOP cycles for a programmable settling gap.

No command leaves the block until the memory clock has been locked for a programmable stabilization time. A request that arrives during the stabilization time or during a gap is held in a single pending slot and sent as soon as the wait ends. The block accepts only this order: precharge-all, refresh, refresh, load-mode. Any other request is dropped and sets a sticky error flag.

Once load-mode and its gap have finished, the block raises a ready flag. From then on it issues auto-refresh commands by itself at a fixed interval.

Top module: `sdramInitSeq`

## Requirements
- R1: In reset and right after it, chip select and the three strobes are all high, ready and error are low, and busy is high.
- R2: Command requests count only when bit 15 of the same write is 1, and that bit latches the enable until reset. Chip select stays high until the enable has been latched. After that, idle cycles are NOP (chip select low, all three strobes high). A write that has a command bit but bit 15 at 0 produces no command and no error.
- R3: Request bits are precharge-all at bit 14, refresh at bit 11 and load-mode at bit 13. Each command lasts exactly one cycle and uses this encoding:
  - Precharge-all: row strobe low, column strobe high, write enable low, address bit 10 high.
  - Refresh: row strobe and column strobe low, write enable high.
  - Load-mode: all three strobes low, the address carries `modeWord`, and the bank is 0.
- R4: No command is issued before STARTUP_CYCLES clocks have passed with `clkLocked` high. A request that is held pending goes out on clock STARTUP_CYCLES, counted from the first edge that sees the lock.
- R5: After a precharge-all or load-mode, at least GAP_CYCLES NOP cycles follow. A pending request goes out GAP_CYCLES+1 cycles after the previous command.
- R6: After a refresh, the gap is the larger of GAP_CYCLES and TRFC_CYCLES.
- R7: A request accepted while the block is idle goes out on the cycle after the write. `busy` is high while stabilization, a pending request or a gap is outstanding.
- R8: The only order accepted is precharge-all, refresh, refresh, load-mode. A request that is out of order, has several command bits, arrives while another is pending, or arrives after load-mode is dropped without a command, and it sets `seqErr`, which stays high until reset.
- R9: `ready` rises GAP_CYCLES+1 cycles after the load-mode command and stays high until reset.
- R10: Once ready, the block issues a refresh command every REFRESH_INTERVAL cycles. The first comes REFRESH_INTERVAL cycles after `ready` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and memory clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkLocked | input | 1 | Memory clock is stable |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 16 | Control word: enable and one-hot request |
| modeWord | input | ROW_BITS | Mode value driven on the address during load-mode |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| addr | output | ROW_BITS | Memory address |
| ba | output | BANK_BITS | Bank select |
| busy | output | 1 | A wait or a pending request is outstanding |
| ready | output | 1 | Initialization complete |
| seqErr | output | 1 | Sticky request-order error |

## Verification
The assertions rely on a few conditions:
- `modeWord` holds steady around the edge on which load-mode is taken.
- REFRESH_INTERVAL is much longer than one cycle, so commands never come back to back.
- `clkLocked` stays high once it has risen.

The stimulus keeps to these conditions:
- It drives every input half a cycle away from the active edge.
- It raises the lock once per reset and never drops it while the block runs.
- It writes at most one request per write strobe, apart from the deliberate bad cases.
- It never changes the mode value during a run.

// File: rtl/sdramInitPkg.sv
package sdramInitPkg;

  // positions of fields in the control word
  localparam int EN_BIT  = 15;
  localparam int PRE_BIT = 14;
  localparam int LMR_BIT = 13;
  localparam int REF_BIT = 11;
  localparam int AP_BIT  = 10;

  typedef enum logic [1:0] {
    CMD_PRE = 2'd0,
    CMD_REF = 2'd1,
    CMD_LMR = 2'd2
  } initCmdE;

  typedef struct packed {
    logic    issue;
    initCmdE cmd;
    logic    enable;
  } pathStrobeT;

endpackage

// File: rtl/sdramInitCtrl.sv
module sdramInitCtrl
  import sdramInitPkg::*;
#(
  parameter int STARTUP_CYCLES   = 12500,
  parameter int GAP_CYCLES       = 63,
  parameter int TRFC_CYCLES      = 7,
  parameter int REFRESH_INTERVAL = 1500
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        clkLocked,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  output pathStrobeT  strobe,
  output logic        busy,
  output logic        ready,
  output logic        seqErr
);

  localparam int REF_GAP   = (TRFC_CYCLES > GAP_CYCLES) ? TRFC_CYCLES : GAP_CYCLES;
  localparam int GAP_W     = $clog2(REF_GAP + 1);
  localparam int START_W   = $clog2(STARTUP_CYCLES + 1);
  localparam int RI_W      = $clog2(REFRESH_INTERVAL + 1);
  localparam int STEP_DONE = 4;

  logic [START_W-1:0] startCnt;
  logic               startDone;
  logic               enReg;
  logic [2:0]         step;
  logic               pend;
  initCmdE            pendCmd;
  logic [GAP_W-1:0]   gapCnt;
  logic               gapZero;
  logic [RI_W-1:0]    refCnt;
  logic [2:0]         reqBits;
  logic [2:0]         expBits;
  initCmdE            stepCmd;
  logic               reqValid;
  logic               accept;
  logic               reject;
  logic               issueInit;
  logic               autoRef;

  // request bits ordered {precharge, refresh, load-mode}
  assign reqBits = {wrData[PRE_BIT], wrData[REF_BIT], wrData[LMR_BIT]};

  always_comb begin
    case (step)
      3'd0:    begin expBits = 3'b100; stepCmd = CMD_PRE; end
      3'd1,
      3'd2:    begin expBits = 3'b010; stepCmd = CMD_REF; end
      3'd3:    begin expBits = 3'b001; stepCmd = CMD_LMR; end
      default: begin expBits = 3'b000; stepCmd = CMD_PRE; end
    endcase
  end

  assign reqValid  = wrEn & wrData[EN_BIT] & (|reqBits);
  assign accept    = reqValid & ~pend & (reqBits == expBits);
  assign reject    = reqValid & ~accept;
  assign gapZero   = (gapCnt == '0);
  assign issueInit = pend & startDone & gapZero;
  assign autoRef   = ready & (refCnt == RI_W'(REFRESH_INTERVAL - 1));

  assign strobe.issue  = issueInit | autoRef;
  assign strobe.cmd    = issueInit ? pendCmd : CMD_REF;
  assign strobe.enable = enReg;
  assign busy          = ~startDone | pend | ~gapZero;

  // stabilization wait after clock lock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startCnt  <= '0;
      startDone <= 1'b0;
    end else if (!startDone) begin
      if (!clkLocked) begin
        startCnt <= '0;
      end else if (startCnt == START_W'(STARTUP_CYCLES - 1)) begin
        startDone <= 1'b1;
      end else begin
        startCnt <= startCnt + 1'b1;
      end
    end
  end

  // request acceptance, ordering and pending slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      step    <= '0;
      pend    <= 1'b0;
      pendCmd <= CMD_PRE;
      seqErr  <= 1'b0;
    end else begin
      if (wrEn && wrData[EN_BIT]) enReg <= 1'b1;
      if (reject) seqErr <= 1'b1;
      if (accept) begin
        pend    <= 1'b1;
        pendCmd <= stepCmd;
        step    <= step + 1'b1;
      end else if (issueInit) begin
        pend <= 1'b0;
      end
    end
  end

  // settling gap, ready flag and refresh interval
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
      ready  <= 1'b0;
      refCnt <= '0;
    end else begin
      if (issueInit) begin
        gapCnt <= (pendCmd == CMD_REF) ? GAP_W'(REF_GAP) : GAP_W'(GAP_CYCLES);
      end else if (!gapZero) begin
        gapCnt <= gapCnt - 1'b1;
      end
      if ((step == 3'(STEP_DONE)) && !pend && gapZero) ready <= 1'b1;
      if (!ready || autoRef) refCnt <= '0;
      else                   refCnt <= refCnt + 1'b1;
    end
  end

  // checker state: cycles since the last init command and the gap it owed
  logic [GAP_W:0]   sinceCmd;
  logic [GAP_W-1:0] owedGap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceCmd <= '1;
      owedGap  <= '0;
    end else if (issueInit) begin
      sinceCmd <= '0;
      owedGap  <= (pendCmd == CMD_REF) ? GAP_W'(REF_GAP) : GAP_W'(GAP_CYCLES);
    end else if (sinceCmd != '1) begin
      sinceCmd <= sinceCmd + 1'b1;
    end
  end

  a_r5_gap_kept: assert property (@(posedge clk) disable iff (!rstN)
    issueInit |-> (sinceCmd >= {1'b0, owedGap}));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    seqErr |=> seqErr);

  a_r9_ready_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

endmodule

// File: rtl/sdramInitPath.sv
module sdramInitPath
  import sdramInitPkg::*;
#(
  parameter int ROW_BITS  = 12,
  parameter int BANK_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pathStrobeT           strobe,
  input  logic [ROW_BITS-1:0]  modeWord,
  output logic                 csN,
  output logic                 rasN,
  output logic                 casN,
  output logic                 weN,
  output logic [ROW_BITS-1:0]  addr,
  output logic [BANK_BITS-1:0] ba
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN  <= 1'b1;
      rasN <= 1'b1;
      casN <= 1'b1;
      weN  <= 1'b1;
      addr <= '0;
      ba   <= '0;
    end else begin
      csN  <= ~strobe.enable;
      rasN <= 1'b1;
      casN <= 1'b1;
      weN  <= 1'b1;
      addr <= '0;
      ba   <= '0;
      if (strobe.issue && strobe.enable) begin
        case (strobe.cmd)
          CMD_PRE: begin
            rasN         <= 1'b0;
            weN          <= 1'b0;
            addr[AP_BIT] <= 1'b1;
          end
          CMD_REF: begin
            rasN <= 1'b0;
            casN <= 1'b0;
          end
          CMD_LMR: begin
            rasN <= 1'b0;
            casN <= 1'b0;
            weN  <= 1'b0;
            addr <= modeWord;
          end
          default: ;
        endcase
      end
    end
  end

  a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (rasN && casN && weN));

  a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !(rasN && casN && weN)) |=> (rasN && casN && weN));

  a_r3_mode_on_addr: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !rasN && !casN && !weN) |-> (addr == $past(modeWord) && ba == '0));

endmodule

// File: rtl/sdramInitSeq.sv
module sdramInitSeq
  import sdramInitPkg::*;
#(
  parameter int STARTUP_CYCLES   = 12500,
  parameter int GAP_CYCLES       = 63,
  parameter int TRFC_CYCLES      = 7,
  parameter int REFRESH_INTERVAL = 1500,
  parameter int ROW_BITS         = 12,
  parameter int BANK_BITS        = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clkLocked,
  input  logic                 ctrlWrEn,
  input  logic [15:0]          ctrlWrData,
  input  logic [ROW_BITS-1:0]  modeWord,
  output logic                 csN,
  output logic                 rasN,
  output logic                 casN,
  output logic                 weN,
  output logic [ROW_BITS-1:0]  addr,
  output logic [BANK_BITS-1:0] ba,
  output logic                 busy,
  output logic                 ready,
  output logic                 seqErr
);

  pathStrobeT strobe;

  sdramInitCtrl #(
    .STARTUP_CYCLES  (STARTUP_CYCLES),
    .GAP_CYCLES      (GAP_CYCLES),
    .TRFC_CYCLES     (TRFC_CYCLES),
    .REFRESH_INTERVAL(REFRESH_INTERVAL)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .clkLocked(clkLocked),
    .wrEn     (ctrlWrEn),
    .wrData   (ctrlWrData),
    .strobe   (strobe),
    .busy     (busy),
    .ready    (ready),
    .seqErr   (seqErr)
  );

  sdramInitPath #(
    .ROW_BITS (ROW_BITS),
    .BANK_BITS(BANK_BITS)
  ) path_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .modeWord(modeWord),
    .csN     (csN),
    .rasN    (rasN),
    .casN    (casN),
    .weN     (weN),
    .addr    (addr),
    .ba      (ba)
  );

endmodule

// File: tb/sdramInitSeq_tb_top.sv
`timescale 1ns/100ps
module sdramInitSeq_tb_top;

  localparam int STARTUP = 20;
  localparam int GAP     = 4;
  localparam int TRFC    = 7;
  localparam int RI      = 40;
  localparam int REF_GAP = (TRFC > GAP) ? TRFC : GAP;
  localparam logic [2:0] K_PRE = 3'b010;
  localparam logic [2:0] K_REF = 3'b001;
  localparam logic [2:0] K_LMR = 3'b000;
  localparam logic [11:0] MODE = 12'h033;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkLocked = 1'b0;
  logic        ctrlWrEn = 1'b0;
  logic [15:0] ctrlWrData = '0;
  logic [11:0] modeWord = MODE;
  logic        csN, rasN, casN, weN, busy, ready, seqErr;
  logic [11:0] addr;
  logic [1:0]  ba;

  sdramInitSeq #(
    .STARTUP_CYCLES(STARTUP), .GAP_CYCLES(GAP), .TRFC_CYCLES(TRFC),
    .REFRESH_INTERVAL(RI), .ROW_BITS(12), .BANK_BITS(2)
  ) dut_i (
    .clk(clk), .rstN(rstN), .clkLocked(clkLocked), .ctrlWrEn(ctrlWrEn),
    .ctrlWrData(ctrlWrData), .modeWord(modeWord), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .addr(addr), .ba(ba), .busy(busy),
    .ready(ready), .seqErr(seqErr)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic [2:0] kind;
    int         at;
    string      req;
  } expT;
  expT q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && !csN && !(rasN && casN && weN)) begin
      logic [2:0] k;
      k = {rasN, casN, weN};
      if (q.size() == 0) begin
        chk(0, "R8", "unexpected command kind", int'(k), 7);
      end else begin
        expT e;
        e = q.pop_front();
        chk(k == e.kind, "R3", "command encoding", int'(k), int'(e.kind));
        chk(cyc == e.at, e.req, "command cycle", cyc, e.at);
        if (e.kind == K_PRE) chk(addr[10] == 1'b1, "R3", "precharge-all A10", int'(addr), 12'h400);
        if (e.kind == K_LMR) chk(addr == MODE && ba == 2'b00, "R3", "load-mode address", int'(addr), int'(MODE));
      end
    end
  end

  int wEdge;
  int lockEdge;

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    ctrlWrEn   = 1'b1;
    ctrlWrData = d;
    wEdge      = cyc + 1;
    @(negedge clk);
    ctrlWrEn   = 1'b0;
    ctrlWrData = '0;
  endtask

  task automatic waitTo(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  function automatic int maxi(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    clkLocked = 1'b0;
    repeat (3) @(negedge clk);
    q.delete();
    chk(csN && rasN && casN && weN, "R1", "pins in reset", int'({csN, rasN, casN, weN}), 4'hf);
    chk(!ready && !seqErr && busy, "R1", "status in reset", int'({ready, seqErr, busy}), 3'b001);
    rstN = 1'b1;
    @(negedge clk);
    chk(csN && rasN && casN && weN, "R1", "pins after reset", int'({csN, rasN, casN, weN}), 4'hf);
    clkLocked = 1'b1;
    lockEdge  = cyc + 1;
  endtask

  initial begin
    int pExp, r1Exp, r2Exp, lExp, rdy;
    // ---------------- phase 1: full legal sequence
    doReset();
    @(negedge clk);
    chk(busy == 1'b1, "R7", "busy during stabilization", int'(busy), 1);
    wr(16'h8000);
    @(negedge clk);
    chk(csN == 1'b0 && rasN && casN && weN, "R2", "NOP after enable", int'({csN, rasN, casN, weN}), 4'h7);
    wr(16'hC000);
    pExp = maxi(wEdge + 1, lockEdge + STARTUP);
    q.push_back('{K_PRE, pExp, "R4"});
    waitTo(pExp);
    wr(16'h8800);
    r1Exp = maxi(wEdge + 1, pExp + GAP + 1);
    q.push_back('{K_REF, r1Exp, "R5"});
    waitTo(r1Exp);
    wr(16'h8800);
    r2Exp = maxi(wEdge + 1, r1Exp + REF_GAP + 1);
    q.push_back('{K_REF, r2Exp, "R6"});
    waitTo(r2Exp);
    while (busy) @(negedge clk);
    wr(16'hA000);
    chk(busy == 1'b1, "R7", "busy with pending request", int'(busy), 1);
    lExp = wEdge + 1;
    q.push_back('{K_LMR, lExp, "R7"});
    waitTo(lExp + GAP);
    chk(ready == 1'b0, "R9", "ready before gap ends", int'(ready), 0);
    @(negedge clk);
    chk(ready == 1'b1, "R9", "ready after load-mode gap", int'(ready), 1);
    rdy = lExp + GAP + 1;
    q.push_back('{K_REF, rdy + RI, "R10"});
    q.push_back('{K_REF, rdy + 2 * RI, "R10"});
    wr(16'hC000);
    @(negedge clk);
    chk(seqErr == 1'b1 && ready == 1'b1, "R8", "request after ready", int'({seqErr, ready}), 3);
    waitTo(rdy + 2 * RI + 3);
    chk(q.size() == 0, "R10", "auto refreshes all seen", q.size(), 0);

    // ---------------- phase 2: ignored and out-of-order requests
    doReset();
    wr(16'h4000);
    repeat (3) @(negedge clk);
    chk(csN == 1'b1 && seqErr == 1'b0, "R2", "request without enable ignored", int'({csN, seqErr}), 2);
    wr(16'h8800);
    @(negedge clk);
    chk(seqErr == 1'b1, "R8", "refresh before precharge flagged", int'(seqErr), 1);
    wr(16'hC000);
    pExp = maxi(wEdge + 1, lockEdge + STARTUP);
    q.push_back('{K_PRE, pExp, "R4"});
    waitTo(pExp + 2);
    chk(q.size() == 0, "R8", "precharge still accepted after error", q.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule